// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block drives a single read or write request across as many AUX channel attempts as it takes to finish. Each attempt is handed to a downstream framer as a command, an address, a length and a buffer offset, using a valid/ready handshake. The outcome of each attempt comes back from a reply classifier as a channel result, a reply code and a returned byte count. The controller then decides whether to retry, change the command, or stop, and it ends with a one-cycle done pulse that carries a final status.

Every failure kind has its own retry counter and its own budget. A read that is only partly acknowledged keeps going from where the returned data ended. For the I2C address space the controller shifts the address, picks the command variant with or without the middle-of-transaction bit, switches a write to status polling after an I2C defer or a pending-byte ACK, and closes the bus with a stop transaction when it has to. It can also insert a programmable idle gap between I2C attempts.

Top module: `aux_rty_ctrl`

## Requirements
- R1: After reset, and until start_i is asserted, req_valid_o, done_o and busy_o are low.
- R2: Command codes on req_cmd_o are: native write 4'b1000, native read 4'b1001, I2C write 4'b0000, I2C read 4'b0001, I2C status request 4'b0010. Bit 2 is set on I2C commands when mot_i is high. Native requests carry addr_i as given, and I2C requests carry addr_i shifted right by one.
- R3: A channel result of invalid (rsp_chan_i=1) ends with protocol error (status 3) on its second occurrence. A channel timeout (rsp_chan_i=2) ends with timeout (status 2) on its third. Any good channel result (rsp_chan_i=0) clears both of these counters.
- R4: A native defer (reply 2) ends with timeout on the 7th occurrence for reads. For writes the limit is the larger of cfg_defer_max_i and 6. A native ACK on a read clears the native defer count.
- R5: On a read ACK (reply 0), a byte count above the remaining length is a protocol error and an equal count is success (status 0). A smaller count retries with the remaining length reduced and the offset advanced by the count. A second partial ACK in one request is a protocol error.
- R6: A native NACK (reply 1) ends with status 1. A disconnect (rsp_chan_i=3) ends with status 4. An I2C NACK (reply 4) or any other unlisted reply ends with status 5.
- R7: On a write, an I2C defer (reply 8) makes the next attempt a status request with length 0 that keeps the MOT bit. The I2C defer count then has the same limit as the native write defer.
- R8: A write ACK with a non-zero byte count makes the next attempt a status request. The 7th such ACK ends with timeout, and a write ACK with zero bytes is success.
- R9: For the I2C space only, once the outcome is known and either mot_i was low or the status is not success, one stop transaction is issued before done. It uses the plain I2C read or write code with MOT cleared and length 0, and its reply does not change the status.
- R10: Between I2C attempts, req_valid_o stays low for cfg_wait_i cycles after the response. A native retry is requested in the cycle right after the response.
- R11: req_valid_o and the request fields hold steady until req_ready_i. done_o is a single-cycle pulse and is never high together with req_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a request (taken when idle) |
| op_write_i | input | 1 | 1 = write, 0 = read |
| i2c_space_i | input | 1 | 1 = I2C address space, 0 = native |
| mot_i | input | 1 | Middle-of-transaction request |
| addr_i | input | ADDR_W | Request address |
| len_i | input | LEN_W | Payload length in bytes |
| cfg_wait_i | input | WAIT_W | Idle cycles between I2C attempts |
| cfg_defer_max_i | input | CNT_W | Configurable write defer maximum |
| req_valid_o | output | 1 | Attempt command valid |
| req_ready_i | input | 1 | Framer accepts command |
| req_cmd_o | output | 4 | Command code |
| req_addr_o | output | ADDR_W | Address sent on the channel |
| req_len_o | output | LEN_W | Attempt length |
| req_off_o | output | LEN_W | Buffer offset of this attempt |
| rsp_valid_i | input | 1 | Classifier result valid |
| rsp_chan_i | input | 2 | 0 ok, 1 invalid, 2 timeout, 3 disconnect |
| rsp_reply_i | input | 4 | 0 ACK, 1 NACK, 2 defer, 4 I2C NACK, 8 I2C defer |
| rsp_bytes_i | input | LEN_W | Returned data byte count |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (one cycle) |
| status_o | output | 3 | 0 ok, 1 NACK, 2 timeout, 3 protocol, 4 disconnect, 5 unknown |

## Verification
The bench works the retry budgets right at their edges. It sends exactly one defer, timeout or status ACK past each limit, so a design off by one either gives up an attempt early or asks for an extra request that the bench never answers. Interleaving an invalid reply, a clean defer and a second invalid reply catches a design that does not clear counters on a good channel result; such a design would return a protocol error instead of success. Partial read ACKs check that the length and offset are carried forward, and repeated I2C write retries check the switch to status requests. Stop transactions are checked for both presence and absence, and the gap before each I2C retry is counted cycle by cycle against native retries, which must have no gap.

// File: rtl/aux_rty_pkg.sv
package aux_rty_pkg;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_NACK = 3'd1, ST_TIMEOUT = 3'd2,
    ST_PROTO = 3'd3, ST_DISCON = 3'd4, ST_UNKNOWN = 3'd5
  } xfer_status_e;

  typedef enum logic [1:0] {
    CH_OK = 2'd0, CH_INVALID = 2'd1, CH_TIMEOUT = 2'd2, CH_DISCON = 2'd3
  } chan_res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_STOP_ISSUE, S_STOP_WAIT, S_DONE
  } fsm_e;

  localparam logic [3:0] RP_ACK       = 4'd0;
  localparam logic [3:0] RP_NACK      = 4'd1;
  localparam logic [3:0] RP_DEFER     = 4'd2;
  localparam logic [3:0] RP_I2C_DEFER = 4'd8;

  // retry counter bank indices
  localparam int K_TMO  = 0;
  localparam int K_INV  = 1;
  localparam int K_DEFA = 2;
  localparam int K_DEFI = 3;
  localparam int K_PART = 4;
  localparam int K_ACKM = 5;
  localparam int NUM_K  = 6;

  localparam int LIM_INV = 1;
  localparam int LIM_TMO = 2;
  localparam int LIM_DEF = 6;
endpackage

// File: rtl/aux_rty_cnt.sv
module aux_rty_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             exceed_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))      cnt_q <= cnt_q + 1'b1;
  end

  // asserted when the next increment would pass the limit
  assign exceed_o = ({1'b0, cnt_q} + 1'b1) > {1'b0, limit_i};
endmodule

// File: rtl/aux_rty_cmd.sv
module aux_rty_cmd #(
  parameter int ADDR_W = 20
) (
  input  logic              wr_i,
  input  logic              i2c_i,
  input  logic              mot_i,
  input  logic              stat_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    if (!i2c_i)          cmd_o = {3'b100, ~wr_i};
    else if (stat_req_i) cmd_o = {1'b0, mot_i, 2'b10};
    else                 cmd_o = {1'b0, mot_i, 1'b0, ~wr_i};
  end

  assign addr_o = i2c_i ? (addr_i >> 1) : addr_i;
endmodule

// File: rtl/aux_rty_gap.sv
module aux_rty_gap #(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  output logic              expired_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/aux_rty_ctrl.sv
module aux_rty_ctrl
  import aux_rty_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int CNT_W  = 4,
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_write_i,
  input  logic              i2c_space_i,
  input  logic              mot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [CNT_W-1:0]  cfg_defer_max_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [3:0]        req_cmd_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [LEN_W-1:0]  req_off_o,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_chan_i,
  input  logic [3:0]        rsp_reply_i,
  input  logic [LEN_W-1:0]  rsp_bytes_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        status_o
);
  localparam logic [CNT_W-1:0] DEF_LIM = CNT_W'(LIM_DEF);

  fsm_e              state_q;
  logic              wr_q, i2c_q, mot_q, stat_req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain_q, off_q;
  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  defmax_q;
  xfer_status_e      status_q;

  logic              stop_phase, rsp_take, gap_load, gap_exp, need_stop;
  logic              fin, shrink, go_stat;
  xfer_status_e      fin_st;
  logic [NUM_K-1:0]  inc_v, clr_v, exc_v;
  logic [CNT_W-1:0]  lim [NUM_K];
  logic [CNT_W-1:0]  wr_def_lim;

  assign stop_phase = (state_q == S_STOP_ISSUE) || (state_q == S_STOP_WAIT);
  assign rsp_take   = (state_q == S_WAIT) && rsp_valid_i;

  // ---- retry counter bank
  assign wr_def_lim = (defmax_q > DEF_LIM) ? defmax_q : DEF_LIM;

  always_comb begin
    lim[K_TMO]  = CNT_W'(LIM_TMO);
    lim[K_INV]  = CNT_W'(LIM_INV);
    lim[K_DEFA] = wr_q ? wr_def_lim : DEF_LIM;
    lim[K_DEFI] = wr_q ? wr_def_lim : DEF_LIM;
    lim[K_PART] = CNT_W'(LIM_INV);
    lim[K_ACKM] = DEF_LIM;
  end

  for (genvar k = 0; k < NUM_K; k++) begin : g_cnt
    aux_rty_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_v[k]),
      .inc_i    (inc_v[k]),
      .limit_i  (lim[k]),
      .exceed_o (exc_v[k])
    );
  end

  // ---- reply decision
  always_comb begin
    inc_v = '0; clr_v = '0;
    fin = 1'b0; fin_st = ST_OK; shrink = 1'b0; go_stat = 1'b0;
    case (chan_res_e'(rsp_chan_i))
      CH_INVALID: begin
        inc_v[K_INV] = 1'b1;
        if (exc_v[K_INV]) begin fin = 1'b1; fin_st = ST_PROTO; end
      end
      CH_TIMEOUT: begin
        inc_v[K_TMO] = 1'b1;
        if (exc_v[K_TMO]) begin fin = 1'b1; fin_st = ST_TIMEOUT; end
      end
      CH_DISCON: begin fin = 1'b1; fin_st = ST_DISCON; end
      default: begin
        clr_v[K_TMO] = 1'b1;
        clr_v[K_INV] = 1'b1;
        case (rsp_reply_i)
          RP_ACK: begin
            if (!wr_q) begin
              clr_v[K_DEFA] = 1'b1;
              if (rsp_bytes_i > remain_q) begin
                fin = 1'b1; fin_st = ST_PROTO;
              end else if (rsp_bytes_i < remain_q) begin
                shrink = 1'b1;
                inc_v[K_PART] = 1'b1;
                if (exc_v[K_PART]) begin fin = 1'b1; fin_st = ST_PROTO; end
              end else begin
                fin = 1'b1;
              end
            end else if (rsp_bytes_i != '0) begin
              go_stat = 1'b1;
              inc_v[K_ACKM] = 1'b1;
              if (exc_v[K_ACKM]) begin fin = 1'b1; fin_st = ST_TIMEOUT; end
            end else begin
              fin = 1'b1;
            end
          end
          RP_NACK: begin fin = 1'b1; fin_st = ST_NACK; end
          RP_DEFER: begin
            inc_v[K_DEFA] = 1'b1;
            if (exc_v[K_DEFA]) begin fin = 1'b1; fin_st = ST_TIMEOUT; end
          end
          RP_I2C_DEFER: begin
            clr_v[K_DEFA] = 1'b1;
            inc_v[K_DEFI] = 1'b1;
            go_stat = wr_q;
            if (exc_v[K_DEFI]) begin fin = 1'b1; fin_st = ST_TIMEOUT; end
          end
          default: begin fin = 1'b1; fin_st = ST_UNKNOWN; end
        endcase
      end
    endcase
    if (!rsp_take) begin
      inc_v = '0; clr_v = '0;
    end
    if ((state_q == S_IDLE) && start_i) clr_v = '1;
  end

  assign need_stop = i2c_q && (!mot_q || (fin_st != ST_OK));
  assign gap_load  = rsp_take && !fin && i2c_q && (wait_q != '0);

  aux_rty_gap #(.WAIT_W(WAIT_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .len_i     (wait_q),
    .expired_o (gap_exp)
  );

  // ---- sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wr_q       <= 1'b0;
      i2c_q      <= 1'b0;
      mot_q      <= 1'b0;
      stat_req_q <= 1'b0;
      addr_q     <= '0;
      remain_q   <= '0;
      off_q      <= '0;
      wait_q     <= '0;
      defmax_q   <= '0;
      status_q   <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          wr_q       <= op_write_i;
          i2c_q      <= i2c_space_i;
          mot_q      <= mot_i;
          stat_req_q <= 1'b0;
          addr_q     <= addr_i;
          remain_q   <= len_i;
          off_q      <= '0;
          wait_q     <= cfg_wait_i;
          defmax_q   <= cfg_defer_max_i;
          status_q   <= ST_OK;
          state_q    <= S_ISSUE;
        end
        S_ISSUE: if (req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (rsp_valid_i) begin
          if (shrink) begin
            remain_q <= remain_q - rsp_bytes_i;
            off_q    <= off_q + rsp_bytes_i;
          end
          if (go_stat) begin
            stat_req_q <= 1'b1;
            remain_q   <= '0;
          end
          if (fin) begin
            status_q <= fin_st;
            state_q  <= need_stop ? S_STOP_ISSUE : S_DONE;
          end else begin
            state_q  <= gap_load ? S_GAP : S_ISSUE;
          end
        end
        S_GAP:        if (gap_exp) state_q <= S_ISSUE;
        S_STOP_ISSUE: if (req_ready_i) state_q <= S_STOP_WAIT;
        S_STOP_WAIT:  if (rsp_valid_i) state_q <= S_DONE;
        default:      state_q <= S_IDLE;
      endcase
    end
  end

  aux_rty_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .wr_i       (wr_q),
    .i2c_i      (i2c_q),
    .mot_i      (mot_q && !stop_phase),
    .stat_req_i (stat_req_q && !stop_phase),
    .addr_i     (addr_q),
    .cmd_o      (req_cmd_o),
    .addr_o     (req_addr_o)
  );

  assign req_valid_o = (state_q == S_ISSUE) || (state_q == S_STOP_ISSUE);
  assign req_len_o   = stop_phase ? '0 : remain_q;
  assign req_off_o   = stop_phase ? '0 : off_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign status_o    = status_q;
endmodule

// File: rtl/aux_rty_chk.sv
module aux_rty_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_i,
  input logic [3:0]       req_cmd_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic             done_i,
  input logic [2:0]       status_i,
  input logic             i2c_i,
  input logic             stop_i
);
  a_r11_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_i |=> req_valid_i && $stable(req_cmd_i) && $stable(req_len_i));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r11_done_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !req_valid_i);

  a_r2_i2c_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && i2c_i |-> !req_cmd_i[3]);

  a_r2_native_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !i2c_i |-> req_cmd_i[3:1] == 3'b100);

  a_r9_stop_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && stop_i |-> i2c_i && !req_cmd_i[2] && (req_len_i == '0));

  a_r6_status_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> status_i <= 3'd5);
endmodule

bind aux_rty_ctrl aux_rty_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_cmd_i   (req_cmd_o),
  .req_len_i   (req_len_o),
  .done_i      (done_o),
  .status_i    (status_o),
  .i2c_i       (i2c_q),
  .stop_i      (stop_phase)
);

// File: tb/sim_aux_rty_ctrl.sv
module sim_aux_rty_ctrl;
  localparam int ADDR_W = 20, LEN_W = 5, CNT_W = 4, WAIT_W = 8;
  localparam int GAP = 3;
  localparam logic [3:0] NW = 4'b1000, NR = 4'b1001, IW = 4'b0000,
                         IR = 4'b0001, IWM = 4'b0100, IRM = 4'b0101, STM = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, op_wr = 0, i2c = 0, mot = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [WAIT_W-1:0] cfg_wait = WAIT_W'(GAP);
  logic [CNT_W-1:0]  cfg_dmax = CNT_W'(8);
  logic req_valid, req_ready = 0;
  logic [3:0] req_cmd;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len, req_off;
  logic rsp_valid = 0;
  logic [1:0] rsp_chan = 0;
  logic [3:0] rsp_reply = 0;
  logic [LEN_W-1:0] rsp_bytes = '0;
  logic busy, done;
  logic [2:0] status;

  int n_chk = 0, n_err = 0;
  logic [2:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  aux_rty_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_write_i(op_wr),
    .i2c_space_i(i2c), .mot_i(mot), .addr_i(addr), .len_i(len),
    .cfg_wait_i(cfg_wait), .cfg_defer_max_i(cfg_dmax),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_cmd_o(req_cmd),
    .req_addr_o(req_addr), .req_len_o(req_len), .req_off_o(req_off),
    .rsp_valid_i(rsp_valid), .rsp_chan_i(rsp_chan), .rsp_reply_i(rsp_reply),
    .rsp_bytes_i(rsp_bytes), .busy_o(busy), .done_o(done), .status_o(status));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected final status on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        automatic logic [2:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(status == e, t, "final status", status, e);
      end
    end
  end

  task automatic begin_op(input bit w, input bit sp, input logic [ADDR_W-1:0] a,
                          input int l, input bit m, input logic [2:0] est, input string t);
    @(negedge clk);
    op_wr = w; i2c = sp; addr = a; len = LEN_W'(l); mot = m; start = 1'b1;
    exp_q.push_back(est); tag_q.push_back(t);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic attempt(input logic [3:0] ecmd, input logic [ADDR_W-1:0] eaddr,
                         input int elen, input int eoff, input int egap,
                         input logic [1:0] ch, input logic [3:0] rp, input int by,
                         input string t);
    int g = 0;
    while (!req_valid && g < 300) begin g++; @(negedge clk); end
    if (egap >= 0) check(g == egap, "R10", "idle gap before attempt", g, egap);
    check(req_cmd == ecmd, t, "command", req_cmd, ecmd);
    check(req_addr == eaddr, t, "address", req_addr, eaddr);
    check(req_len == LEN_W'(elen), t, "length", req_len, elen);
    check(req_off == LEN_W'(eoff), t, "offset", req_off, eoff);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_chan = ch; rsp_reply = rp; rsp_bytes = LEN_W'(by);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic end_op(input string t);
    int w = 0;
    while (exp_q.size() != 0 && w < 40) begin w++; @(negedge clk); end
    check(exp_q.size() == 0, t, "done reached without extra request", exp_q.size(), 0);
    check(!req_valid && !busy, t, "idle after done", req_valid, 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!req_valid && !done && !busy, "R1", "outputs in reset", req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!req_valid && !done && !busy, "R1", "idle after reset", busy, 0);

    // native read, full ACK
    begin_op(0, 0, 20'h00123, 4, 0, 3'd0, "R2");
    attempt(NR, 20'h00123, 4, 0, 0, 2'd0, 4'd0, 4, "R2");
    end_op("R2");

    // I2C read, partial ACK, gap, then stop
    begin_op(0, 1, 20'h000A0, 4, 0, 3'd0, "R5");
    attempt(IR, 20'h00050, 4, 0, 0, 2'd0, 4'd0, 2, "R5");
    attempt(IR, 20'h00050, 2, 2, GAP, 2'd0, 4'd0, 2, "R5");
    attempt(IR, 20'h00050, 0, 0, 0, 2'd0, 4'd0, 0, "R9");
    end_op("R9");

    // second partial ACK is protocol error
    begin_op(0, 0, 20'h00300, 4, 0, 3'd3, "R5");
    attempt(NR, 20'h00300, 4, 0, 0, 2'd0, 4'd0, 1, "R5");
    attempt(NR, 20'h00300, 3, 1, 0, 2'd0, 4'd0, 1, "R5");
    end_op("R5");

    // too many bytes returned
    begin_op(0, 0, 20'h00301, 2, 0, 3'd3, "R5");
    attempt(NR, 20'h00301, 2, 0, 0, 2'd0, 4'd0, 3, "R5");
    end_op("R5");

    // channel timeouts: third fails
    begin_op(1, 0, 20'h00200, 2, 0, 3'd2, "R3");
    for (int i = 0; i < 3; i++) attempt(NW, 20'h00200, 2, 0, 0, 2'd2, 4'd0, 0, "R3");
    end_op("R3");

    // invalid counter cleared by a good channel result
    begin_op(0, 0, 20'h00210, 2, 0, 3'd0, "R3");
    attempt(NR, 20'h00210, 2, 0, 0, 2'd1, 4'd0, 0, "R3");
    attempt(NR, 20'h00210, 2, 0, 0, 2'd0, 4'd2, 0, "R3");
    attempt(NR, 20'h00210, 2, 0, 0, 2'd1, 4'd0, 0, "R3");
    attempt(NR, 20'h00210, 2, 0, 0, 2'd0, 4'd0, 2, "R3");
    end_op("R3");

    // two invalid in a row
    begin_op(0, 0, 20'h00211, 1, 0, 3'd3, "R3");
    attempt(NR, 20'h00211, 1, 0, 0, 2'd1, 4'd0, 0, "R3");
    attempt(NR, 20'h00211, 1, 0, 0, 2'd1, 4'd0, 0, "R3");
    end_op("R3");

    // read defer limit 6 even with cfg 8
    begin_op(0, 0, 20'h00400, 1, 0, 3'd2, "R4");
    for (int i = 0; i < 7; i++) attempt(NR, 20'h00400, 1, 0, 0, 2'd0, 4'd2, 0, "R4");
    end_op("R4");

    // write defer limit max(cfg=8,6)
    begin_op(1, 0, 20'h00401, 1, 0, 3'd2, "R4");
    for (int i = 0; i < 9; i++) attempt(NW, 20'h00401, 1, 0, 0, 2'd0, 4'd2, 0, "R4");
    end_op("R4");

    // native NACK and disconnect
    begin_op(0, 0, 20'h00500, 1, 0, 3'd1, "R6");
    attempt(NR, 20'h00500, 1, 0, 0, 2'd0, 4'd1, 0, "R6");
    end_op("R6");
    begin_op(1, 0, 20'h00501, 1, 0, 3'd4, "R6");
    attempt(NW, 20'h00501, 1, 0, 0, 2'd3, 4'd0, 0, "R6");
    end_op("R6");

    // I2C write with MOT: I2C defer -> status request, success, no stop
    begin_op(1, 1, 20'h000A0, 3, 1, 3'd0, "R7");
    attempt(IWM, 20'h00050, 3, 0, 0, 2'd0, 4'd8, 0, "R7");
    attempt(STM, 20'h00050, 0, 0, GAP, 2'd0, 4'd0, 0, "R7");
    end_op("R9");

    // write ACK with pending bytes: 7th fails, then stop
    begin_op(1, 1, 20'h000A2, 1, 1, 3'd2, "R8");
    attempt(IWM, 20'h00051, 1, 0, 0, 2'd0, 4'd0, 1, "R8");
    for (int i = 0; i < 6; i++) attempt(STM, 20'h00051, 0, 0, GAP, 2'd0, 4'd0, 1, "R8");
    attempt(IW, 20'h00051, 0, 0, 0, 2'd0, 4'd0, 0, "R9");
    end_op("R8");

    // I2C NACK on read: unknown, stop despite MOT
    begin_op(0, 1, 20'h000A4, 2, 1, 3'd5, "R6");
    attempt(IRM, 20'h00052, 2, 0, 0, 2'd0, 4'd4, 0, "R6");
    attempt(IR, 20'h00052, 0, 0, 0, 2'd0, 4'd0, 0, "R9");
    end_op("R6");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule